// File: doc/BRIEF.md
# Page-Granular Cache Flush Engine

This block sequences maintenance operations on a direct-mapped data cache whose line states distinguish invalid, clean and modified lines. Software writes a 64-bit command word that names one 4 KB linear page and a mode. The engine then steps through every line address of that page. It looks up the tag and state of each line and acts only on lines that hold that page. In flush mode, modified lines are written back through a request/acknowledge handshake and invalidated afterwards. In invalidate-only mode, matching lines are dropped without a write-back.

A separate global flush input runs a two-phase operation over the whole cache. The first phase writes back every modified line. The second phase marks every line invalid. A translation-fault input that is high when a command is written stops the command: the engine records a fault flag in the readable command word and makes no cache access. With the default parameters the cache holds 64 KB in 32-byte lines (2048 entries). The index is address bits 15:5 and the tag is bits 31:16, so one page covers 128 consecutive indices.

Top module: `page_flush_engine`

## Requirements
- R1: After reset `busy` is 0, `reg_rdata` reads all zeros, and `wb_req` and `arr_wr_en` stay 0 whenever `busy` is 0.
- R2: A write on `reg_wr_en` while `busy` is 0, with `gflush` and `xlat_fault` both 0, is accepted. `busy` is 1 from the next cycle on. The read-back then returns the page from write bits 31:12 and the mode from bit 0. All other bits read 0, so a written bit 8 and the reserved bits are dropped.
- R3: Mode bit 0 = 1 (flush): every line of the page whose state is valid and whose tag equals page bits 19:4 is handled, at index {page[3:0], line 0..127}. A matching modified line first raises `wb_req` with `wb_addr` = {tag, index, 5'b0}, and it is invalidated only in the cycle its `wb_ack` arrives. Line states are 2'b00 invalid, 2'b01 clean, 2'b10 modified.
- R4: Mode bit 0 = 0 (invalidate-only): matching lines, modified ones included, are invalidated without any write-back request.
- R5: Lines of the page's index range that are invalid or hold a different tag are left unchanged, and so are lines outside that range.
- R6: A page walk with no write-backs keeps `busy` high for exactly 128 cycles. With write-backs, `busy` stays high until the last line has been handled.
- R7: A write accepted while `xlat_fault` is 1 stores the command and sets read-back bit 8. It leaves `busy` at 0 and touches no line. The next accepted write with `xlat_fault` at 0 clears bit 8.
- R8: Writes that arrive while `busy` is 1 are ignored. The read-back and the cache contents show no trace of them.
- R9: `gflush` sampled high while idle starts a global operation. Every modified line in the cache is written back in ascending index order. Only after the last write-back is acknowledged is every line marked invalid.
- R10: When `gflush` and a register write arrive in the same idle cycle, the global operation starts and the register write is dropped.
- R11: Once `wb_req` is raised, it stays high and `wb_addr` stays constant until `wb_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Command register write strobe |
| reg_wdata | input | 64 | Command word to write |
| reg_rdata | output | 64 | Command register read-back including fault flag |
| xlat_fault | input | 1 | Translation fault for the page being written |
| gflush | input | 1 | Global write-back-and-invalidate request |
| arr_idx | output | 11 | Tag/state array line index |
| arr_tag | input | 16 | Tag of the addressed line |
| arr_state | input | 2 | State of the addressed line |
| arr_wr_en | output | 1 | Mark the addressed line invalid |
| wb_req | output | 1 | Write-back request |
| wb_addr | output | 32 | Line address to write back |
| wb_ack | input | 1 | Write-back acknowledge |
| busy | output | 1 | Engine is running an operation |

## Verification
The two functions that can collide in the same cycle are a command-register write and a global flush request. Both are taken only while the engine is idle. The bench raises `gflush` and `reg_wr_en` on the same idle clock edge, carrying a different page in the write. It then lets the global operation run to completion. The global write-back order and the final all-invalid array decide whether the flush won, and an unchanged register read-back shows that the write was dropped. The same kind of contention is provoked in a second form: a command write lands in the middle of a page walk, and the scoreboard must still see only the write-backs of the original page.

// File: rtl/pfe_pkg.sv
package pfe_pkg;

    typedef enum logic [2:0] {
        W_IDLE,
        W_PG_LOOK,
        W_PG_WB,
        W_GF_SCAN,
        W_GF_WB,
        W_GF_INV
    } walk_state_e;

    localparam logic [1:0] LS_INVALID  = 2'b00;
    localparam logic [1:0] LS_CLEAN    = 2'b01;
    localparam logic [1:0] LS_MODIFIED = 2'b10;

    localparam int CMD_W         = 64;
    localparam int CMD_FAULT_BIT = 8;
    localparam int CMD_MODE_BIT  = 0;

endpackage

// File: rtl/pfe_cmd_reg.sv
module pfe_cmd_reg #(
    parameter int PAGE_W   = 20,
    parameter int PG_SHIFT = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     accept,
    input  logic [PAGE_W-1:0]        page_in,
    input  logic                     mode_in,
    input  logic                     fault_in,
    output logic [PAGE_W-1:0]        page_q,
    output logic                     mode_q,
    output logic [pfe_pkg::CMD_W-1:0] rdata
);
    import pfe_pkg::*;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic              mode;
        logic              fault;
    } cmd_s;

    cmd_s cmd_d, cmd_q;

    always_comb begin
        cmd_d = cmd_q;
        if (accept) begin
            cmd_d.page  = page_in;
            cmd_d.mode  = mode_in;
            cmd_d.fault = fault_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else begin
            cmd_q <= cmd_d;
        end
    end

    always_comb begin
        rdata                                = '0;
        rdata[PG_SHIFT +: PAGE_W]            = cmd_q.page;
        rdata[CMD_FAULT_BIT]                 = cmd_q.fault;
        rdata[CMD_MODE_BIT]                  = cmd_q.mode;
    end

    assign page_q = cmd_q.page;
    assign mode_q = cmd_q.mode;

endmodule

// File: rtl/pfe_walker.sv
module pfe_walker #(
    parameter int ADDR_W      = 32,
    parameter int LINE_BYTES  = 32,
    parameter int CACHE_BYTES = 65536,
    parameter int PAGE_BYTES  = 4096
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       start,
    input  logic                                       gflush,
    input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0]       page,
    input  logic                                       flush_mode,
    input  logic [ADDR_W-$clog2(CACHE_BYTES)-1:0]      arr_tag,
    input  logic [1:0]                                 arr_state,
    input  logic                                       wb_ack,
    output logic [$clog2(CACHE_BYTES/LINE_BYTES)-1:0]  arr_idx,
    output logic                                       arr_wr_en,
    output logic                                       wb_req,
    output logic [ADDR_W-1:0]                          wb_addr,
    output logic                                       idle
);
    import pfe_pkg::*;

    localparam int OFF_W    = $clog2(LINE_BYTES);
    localparam int PG_SHIFT = $clog2(PAGE_BYTES);
    localparam int NLINES   = CACHE_BYTES / LINE_BYTES;
    localparam int IDX_W    = $clog2(NLINES);
    localparam int TAG_W    = ADDR_W - IDX_W - OFF_W;
    localparam int LPP      = PAGE_BYTES / LINE_BYTES;
    localparam int LPP_W    = $clog2(LPP);
    localparam int PAGE_W   = ADDR_W - PG_SHIFT;
    localparam int HI_W     = IDX_W - LPP_W;

    typedef struct packed {
        walk_state_e      st;
        logic [IDX_W-1:0] cnt;
    } walk_s;

    walk_s w_d, w_q;

    logic [IDX_W-1:0] idx;
    logic             page_phase;
    logic             hit;
    logic             dirty;
    logic             last_pg;
    logic             last_all;

    assign page_phase = (w_q.st == W_PG_LOOK) || (w_q.st == W_PG_WB);
    assign idx        = page_phase ? {page[HI_W-1:0], w_q.cnt[LPP_W-1:0]} : w_q.cnt;
    assign dirty      = (arr_state == LS_MODIFIED);
    assign hit        = (arr_state != LS_INVALID) && (arr_tag == page[PAGE_W-1:HI_W]);
    assign last_pg    = (w_q.cnt[LPP_W-1:0] == LPP_W'(LPP - 1));
    assign last_all   = (w_q.cnt == IDX_W'(NLINES - 1));

    always_comb begin
        w_d       = w_q;
        arr_wr_en = 1'b0;
        wb_req    = 1'b0;
        unique case (w_q.st)
            W_IDLE: begin
                w_d.cnt = '0;
                if (gflush) begin
                    w_d.st = W_GF_SCAN;
                end else if (start) begin
                    w_d.st = W_PG_LOOK;
                end
            end
            W_PG_LOOK: begin
                if (hit && dirty && flush_mode) begin
                    w_d.st = W_PG_WB;
                end else begin
                    arr_wr_en = hit;
                    w_d.cnt   = w_q.cnt + 1'b1;
                    if (last_pg) begin
                        w_d.st = W_IDLE;
                    end
                end
            end
            W_PG_WB: begin
                wb_req = 1'b1;
                if (wb_ack) begin
                    arr_wr_en = 1'b1;
                    w_d.cnt   = w_q.cnt + 1'b1;
                    w_d.st    = last_pg ? W_IDLE : W_PG_LOOK;
                end
            end
            W_GF_SCAN: begin
                if (dirty) begin
                    w_d.st = W_GF_WB;
                end else begin
                    w_d.cnt = w_q.cnt + 1'b1;
                    if (last_all) begin
                        w_d.st = W_GF_INV;
                    end
                end
            end
            W_GF_WB: begin
                wb_req = 1'b1;
                if (wb_ack) begin
                    w_d.cnt = w_q.cnt + 1'b1;
                    w_d.st  = last_all ? W_GF_INV : W_GF_SCAN;
                end
            end
            W_GF_INV: begin
                arr_wr_en = 1'b1;
                w_d.cnt   = w_q.cnt + 1'b1;
                if (last_all) begin
                    w_d.st = W_IDLE;
                end
            end
            default: w_d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q <= '{st: W_IDLE, cnt: '0};
        end else begin
            w_q <= w_d;
        end
    end

    assign arr_idx = idx;
    assign wb_addr = {arr_tag, idx, {OFF_W{1'b0}}};
    assign idle    = (w_q.st == W_IDLE);

endmodule

// File: rtl/page_flush_engine.sv
module page_flush_engine #(
    parameter int ADDR_W      = 32,
    parameter int LINE_BYTES  = 32,
    parameter int CACHE_BYTES = 65536,
    parameter int PAGE_BYTES  = 4096
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       reg_wr_en,
    input  logic [63:0]                                reg_wdata,
    output logic [63:0]                                reg_rdata,
    input  logic                                       xlat_fault,
    input  logic                                       gflush,
    output logic [$clog2(CACHE_BYTES/LINE_BYTES)-1:0]  arr_idx,
    input  logic [ADDR_W-$clog2(CACHE_BYTES)-1:0]      arr_tag,
    input  logic [1:0]                                 arr_state,
    output logic                                       arr_wr_en,
    output logic                                       wb_req,
    output logic [ADDR_W-1:0]                          wb_addr,
    input  logic                                       wb_ack,
    output logic                                       busy
);
    localparam int PG_SHIFT = $clog2(PAGE_BYTES);
    localparam int PAGE_W   = ADDR_W - PG_SHIFT;

    logic              idle;
    logic              accept;
    logic              start;
    logic [PAGE_W-1:0] page_q;
    logic              mode_q;
    logic              unused_wdata;

    assign accept       = reg_wr_en && idle && !gflush;
    assign start        = accept && !xlat_fault;
    assign busy         = !idle;
    assign unused_wdata = ^{reg_wdata[63:ADDR_W], reg_wdata[PG_SHIFT-1:1]};

    pfe_cmd_reg #(
        .PAGE_W   (PAGE_W),
        .PG_SHIFT (PG_SHIFT)
    ) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .page_in  (reg_wdata[ADDR_W-1:PG_SHIFT]),
        .mode_in  (reg_wdata[0]),
        .fault_in (xlat_fault),
        .page_q   (page_q),
        .mode_q   (mode_q),
        .rdata    (reg_rdata)
    );

    pfe_walker #(
        .ADDR_W      (ADDR_W),
        .LINE_BYTES  (LINE_BYTES),
        .CACHE_BYTES (CACHE_BYTES),
        .PAGE_BYTES  (PAGE_BYTES)
    ) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .gflush     (gflush),
        .page       (page_q),
        .flush_mode (mode_q),
        .arr_tag    (arr_tag),
        .arr_state  (arr_state),
        .wb_ack     (wb_ack),
        .arr_idx    (arr_idx),
        .arr_wr_en  (arr_wr_en),
        .wb_req     (wb_req),
        .wb_addr    (wb_addr),
        .idle       (idle)
    );

endmodule

// File: rtl/pfe_checker.sv
module pfe_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              reg_wr_en,
    input logic              gflush,
    input logic              xlat_fault,
    input logic [63:0]       reg_rdata,
    input logic              wb_req,
    input logic              wb_ack,
    input logic [ADDR_W-1:0] wb_addr,
    input logic              arr_wr_en
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!wb_req && !arr_wr_en));

    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && !busy && !gflush && !xlat_fault) |=> busy);

    p_inval_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_ack) |-> !arr_wr_en);

    p_fault_noop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && !busy && !gflush && xlat_fault) |=> (!busy && reg_rdata[8]));

    p_busy_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr_en) |=> $stable(reg_rdata));

    p_gflush_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (gflush && !busy) |=> busy);

    p_gflush_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (gflush && reg_wr_en && !busy) |=> $stable(reg_rdata));

    p_wb_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_ack) |=> (wb_req && $stable(wb_addr)));

endmodule

bind page_flush_engine pfe_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .reg_wr_en  (reg_wr_en),
    .gflush     (gflush),
    .xlat_fault (xlat_fault),
    .reg_rdata  (reg_rdata),
    .wb_req     (wb_req),
    .wb_ack     (wb_ack),
    .wb_addr    (wb_addr),
    .arr_wr_en  (arr_wr_en)
);

// File: tb/sim_page_flush_engine.sv
`timescale 1ns/1ps
module sim_page_flush_engine;

    localparam int IDX_W = 11;
    localparam int TAG_W = 16;
    localparam int NL    = 2048;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr_en = 1'b0;
    logic [63:0]       reg_wdata = '0;
    logic [63:0]       reg_rdata;
    logic              xlat_fault = 1'b0;
    logic              gflush = 1'b0;
    logic [IDX_W-1:0]  arr_idx;
    logic [TAG_W-1:0]  arr_tag;
    logic [1:0]        arr_state;
    logic              arr_wr_en;
    logic              wb_req;
    logic [31:0]       wb_addr;
    logic              wb_ack = 1'b0;
    logic              busy;

    page_flush_engine u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .xlat_fault(xlat_fault), .gflush(gflush),
        .arr_idx(arr_idx), .arr_tag(arr_tag), .arr_state(arr_state),
        .arr_wr_en(arr_wr_en), .wb_req(wb_req), .wb_addr(wb_addr),
        .wb_ack(wb_ack), .busy(busy)
    );

    always #2.5 clk = ~clk;

    // tag/state array model
    logic [TAG_W-1:0] tag_m [NL];
    logic [1:0]       st_m  [NL];
    logic [1:0]       exp_st[NL];
    assign arr_tag   = tag_m[arr_idx];
    assign arr_state = st_m[arr_idx];

    int          checks = 0;
    int          fails  = 0;
    bit          done   = 0;
    bit          gf_phase = 0;
    string       cur_req = "R3";
    logic [31:0] exp_q[$];
    logic [31:0] req_addr;
    int          wait_n = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // array write model plus global ordering check (R9)
    always @(posedge clk) begin
        if (arr_wr_en) begin
            if (gf_phase && exp_q.size() != 0)
                chk(0, "R9", "invalidate before write-backs done", 64'(exp_q.size()), 64'd0);
            st_m[arr_idx] <= 2'b00;
        end
    end

    // memory responder and scoreboard monitor
    always @(negedge clk) begin
        if (wb_ack) begin
            wb_ack = 1'b0;
            wait_n = 0;
        end else if (wb_req) begin
            if (wait_n == 0) req_addr = wb_addr;
            else if (wb_addr != req_addr)
                chk(0, "R11", "wb_addr moved while waiting", 64'(wb_addr), 64'(req_addr));
            if (wait_n == 2) begin
                wb_ack = 1'b1;
                if (exp_q.size() == 0) begin
                    chk(0, cur_req, "unexpected write-back", 64'(wb_addr), 64'd0);
                end else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    chk(wb_addr == e, cur_req, "write-back address", 64'(wb_addr), 64'(e));
                end
            end
            wait_n = wait_n + 1;
        end
    end

    function automatic logic [63:0] mk(input logic [19:0] pg, input logic mode);
        return {32'h0, pg, 3'b000, 1'b0, 7'h00, mode};
    endfunction

    task automatic setline(input int idx, input logic [15:0] tg, input logic [1:0] st);
        tag_m[idx] = tg;
        st_m[idx]  = st;
    endtask

    task automatic snap();
        for (int i = 0; i < NL; i++) exp_st[i] = st_m[i];
    endtask

    // driver: expected write-backs and final states of a page command
    task automatic exp_page(input logic [19:0] pg, input logic mode);
        for (int j = 0; j < 128; j++) begin
            int idx;
            idx = {pg[3:0], 7'(j)};
            if (st_m[idx] != 2'b00 && tag_m[idx] == pg[19:4]) begin
                if (mode && st_m[idx] == 2'b10) exp_q.push_back({tag_m[idx], 11'(idx), 5'b0});
                exp_st[idx] = 2'b00;
            end
        end
    endtask

    task automatic exp_global();
        for (int i = 0; i < NL; i++) begin
            if (st_m[i] == 2'b10) exp_q.push_back({tag_m[i], 11'(i), 5'b0});
            exp_st[i] = 2'b00;
        end
    endtask

    task automatic cmp_states(input string req);
        int bad = 0;
        for (int i = 0; i < NL; i++) if (st_m[i] !== exp_st[i]) bad++;
        chk(bad == 0, req, "mismatching line states", 64'(bad), 64'd0);
    endtask

    task automatic wr_cmd(input logic [63:0] d, input logic flt);
        @(negedge clk);
        reg_wr_en  = 1'b1;
        reg_wdata  = d;
        xlat_fault = flt;
        @(negedge clk);
        reg_wr_en  = 1'b0;
        xlat_fault = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 20000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        logic [63:0] prev;
        for (int i = 0; i < NL; i++) begin
            tag_m[i] = '0;
            st_m[i]  = 2'b00;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(busy == 1'b0, "R1", "busy after reset", 64'(busy), 64'd0);
        chk(reg_rdata == 64'd0, "R1", "read-back after reset", reg_rdata, 64'd0);
        chk(wb_req == 1'b0 && arr_wr_en == 1'b0, "R1", "idle requests", 64'({wb_req, arr_wr_en}), 64'd0);

        // R3/R5/R8/R2: flush mode on page ABCDE (index base 0x700, tag ABCD)
        setline(12'h700, 16'hABCD, 2'b10);
        setline(12'h705, 16'hABCD, 2'b01);
        setline(12'h709, 16'h1234, 2'b10);
        setline(12'h740, 16'hABCD, 2'b10);
        setline(12'h77F, 16'hABCD, 2'b10);
        setline(12'h6FF, 16'hABCD, 2'b10);
        snap();
        cur_req = "R3";
        exp_page(20'hABCDE, 1'b1);
        wr_cmd({32'hDEAD_BEEF, 20'hABCDE, 3'b111, 1'b1, 7'h7F, 1'b1}, 1'b0);
        chk(busy == 1'b1, "R2", "busy after accepted write", 64'(busy), 64'd1);
        chk(reg_rdata == mk(20'hABCDE, 1'b1), "R2", "read-back drops reserved and bit 8",
            reg_rdata, mk(20'hABCDE, 1'b1));
        wr_cmd(mk(20'h11111, 1'b0), 1'b0);
        wait_idle(n);
        chk(reg_rdata == mk(20'hABCDE, 1'b1), "R8", "write while busy ignored",
            reg_rdata, mk(20'hABCDE, 1'b1));
        chk(exp_q.size() == 0, "R3", "outstanding write-backs", 64'(exp_q.size()), 64'd0);
        cmp_states("R5");

        // R4/R6: invalidate-only on page 00053 (index base 0x180, tag 0005)
        setline(12'h181, 16'h0005, 2'b10);
        setline(12'h182, 16'h0005, 2'b01);
        setline(12'h183, 16'h0006, 2'b01);
        snap();
        cur_req = "R4";
        exp_page(20'h00053, 1'b0);
        wr_cmd(mk(20'h00053, 1'b0), 1'b0);
        wait_idle(n);
        chk(n == 128, "R6", "busy cycles of walk without write-back", 64'(n), 64'd128);
        chk(exp_q.size() == 0, "R4", "outstanding write-backs", 64'(exp_q.size()), 64'd0);
        cmp_states("R4");

        // R7: translation fault blocks the command
        setline(12'h507, 16'h5432, 2'b10);
        snap();
        cur_req = "R7";
        wr_cmd(mk(20'h5432A, 1'b1), 1'b1);
        chk(busy == 1'b0, "R7", "busy after faulting write", 64'(busy), 64'd0);
        chk(reg_rdata == (mk(20'h5432A, 1'b1) | 64'h100), "R7", "fault flag set",
            reg_rdata, mk(20'h5432A, 1'b1) | 64'h100);
        repeat (20) @(negedge clk);
        cmp_states("R7");
        snap();
        exp_page(20'h00077, 1'b0);
        wr_cmd(mk(20'h00077, 1'b0), 1'b0);
        chk(reg_rdata[8] == 1'b0, "R7", "fault flag cleared", 64'(reg_rdata[8]), 64'd0);
        wait_idle(n);
        cmp_states("R7");

        // R9/R10: global flush colliding with a register write
        setline(3,    16'h0001, 2'b10);
        setline(1000, 16'h0F0F, 2'b10);
        setline(1001, 16'h0F0F, 2'b01);
        setline(2047, 16'hFFFF, 2'b10);
        snap();
        exp_global();
        prev = reg_rdata;
        cur_req = "R9";
        @(negedge clk);
        gf_phase  = 1'b1;
        gflush    = 1'b1;
        reg_wr_en = 1'b1;
        reg_wdata = mk(20'h22222, 1'b1);
        @(negedge clk);
        gflush    = 1'b0;
        reg_wr_en = 1'b0;
        chk(busy == 1'b1, "R9", "busy after global request", 64'(busy), 64'd1);
        wait_idle(n);
        gf_phase = 1'b0;
        chk(reg_rdata == prev, "R10", "colliding write dropped", reg_rdata, prev);
        chk(exp_q.size() == 0, "R9", "outstanding write-backs", 64'(exp_q.size()), 64'd0);
        cmp_states("R9");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule